// File: doc/BRIEF.md
# Interrupt and Soft-Reset Register Unit

This unit sits beside a serial peripheral core. It turns the core's one-cycle event strobes into sticky interrupt flags and masks each flag on its own. A single global gate then drives one registered interrupt line toward the system interrupt controller. Software reads the flags and acknowledges them by writing back ones. Each written one clears the matching flag.

The same register space holds a keyed reset port. A write of the correct key pulses the core reset output for a fixed number of cycles and returns the unit's own interrupt state to its reset values. A write of any other value leaves the core running. It sets a dedicated error flag that can itself raise the interrupt.

Register access uses a simple 32-bit bus. A write happens in any cycle where the write strobe is high. Read data is a combinational function of the address.

Top module: `irq_sreg_top`

## Requirements
- R1: Register map: global gate at 0x1C (bit 31 only), flag register at 0x20 (bits 7:0), mask register at 0x28 (bits 7:0), key port at 0x40. Unimplemented bits and unmapped addresses read as zero, and writes to them have no effect. The key port always reads zero.
- R2: A high level on `evt_i[i]` at a clock edge sets flag bit i, and the flag stays set until software clears it. Bit meanings: 0 mode fault, 1 target-mode fault, 2 transmit queue empty, 3 transmit underrun, 4 receive queue full, 5 receive overrun, 6 transmit queue half empty, 7 bad reset key.
- R3: Writing 0x20 clears each flag bit whose written bit is 1. Flag bits written as 0 keep their value.
- R4: When a flag clear and an event for the same bit occur in the same cycle, the bit ends up set.
- R5: `irq_o` is registered. It equals gate AND OR(flags AND mask), using the register state one cycle earlier.
- R6: While the global gate bit is 0, `irq_o` stays low whatever the flags and mask hold.
- R7: Writing exactly 0x0000000A to 0x40 drives `core_rst_o` high for exactly RST_CYCLES (default 16) consecutive cycles, starting the cycle after the write.
- R8: A valid key write clears the flag, mask and global gate registers.
- R9: Writing any other value to 0x40 leaves `core_rst_o` low and sets flag bit 7.
- R10: While `core_rst_o` is high, the seven event inputs are ignored.
- R11: After reset, all registers read zero and `irq_o` and `core_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_i | input | 7 | One-cycle event strobes from the core |
| irq_o | output | 1 | Registered interrupt request |
| core_rst_o | output | 1 | Reset to the attached core, active high |

## Verification
The hardest case to reach is an acknowledge write landing in the same clock cycle as a new event on that bit. The bench holds the event strobe and the write strobe across one common edge. It then reads the flag back. Events that arrive while the core reset is active are another hard case. Their effect is only visible after the pulse ends, so the bench fires every event input mid-pulse and reads the flag register once the pulse has finished.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int NUM_EVT  = 7;
  localparam int NUM_SRC  = NUM_EVT + 1;
  localparam int BADKEY_BIT = NUM_EVT;
  localparam int GATE_BIT = 31;

  localparam logic [ADDR_W-1:0] OFS_GATE = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_FLAG = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 8'h40;

  localparam logic [DATA_W-1:0] RESET_KEY = 32'h0000_000A;
endpackage

// File: rtl/isr_src_bank.sv
module isr_src_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         wipe_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_d;
  logic [N-1:0] flag_q;

  for (genvar b = 0; b < N; b++) begin : g_bit
    // set beats clear; wipe beats both
    always_comb begin
      if (wipe_i)        flag_d[b] = 1'b0;
      else if (set_i[b]) flag_d[b] = 1'b1;
      else if (clr_i[b]) flag_d[b] = 1'b0;
      else               flag_d[b] = flag_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[b] <= 1'b0;
      else        flag_q[b] <= flag_d[b];
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/isr_irq_merge.sv
module isr_irq_merge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_i,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic [N-1:0] hit;
  logic         irq_d;
  logic         irq_q;

  for (genvar b = 0; b < N; b++) begin : g_hit
    assign hit[b] = flag_i[b] & mask_i[b];
  end

  always_comb irq_d = gate_i & (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/isr_key_reset.sv
module isr_key_reset #(
  parameter int          DW         = 32,
  parameter logic [DW-1:0] KEY      = 32'h0000_000A,
  parameter int          RST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [DW-1:0] wdata_i,
  output logic          key_ok_o,
  output logic          key_bad_o,
  output logic          core_rst_o
);
  localparam int CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(RST_CYCLES - 1);

  logic             match;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             act_d, act_q;
  logic             cnt_en;

  always_comb begin
    match     = (wdata_i == KEY);
    key_ok_o  = hit_i & match;
    key_bad_o = hit_i & ~match;
  end

  always_comb begin
    cnt_en = key_ok_o | act_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    if (key_ok_o) begin
      cnt_d = LOAD;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign core_rst_o = act_q;
endmodule

// File: rtl/irq_sreg_top.sv
module irq_sreg_top #(
  parameter int RST_CYCLES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr_en,
  input  logic [isr_pkg::ADDR_W-1:0] bus_addr,
  input  logic [isr_pkg::DATA_W-1:0] bus_wdata,
  output logic [isr_pkg::DATA_W-1:0] bus_rdata,
  input  logic [isr_pkg::NUM_EVT-1:0] evt_i,
  output logic                      irq_o,
  output logic                      core_rst_o
);
  import isr_pkg::*;

  logic               wr_gate, wr_flag, wr_mask, wr_key;
  logic               key_ok, key_bad;
  logic [NUM_SRC-1:0] set_vec, clr_vec;
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] mask_d, mask_q;
  logic               mask_en;
  logic               gate_d, gate_q;
  logic               gate_en;

  always_comb begin
    wr_gate = bus_wr_en & (bus_addr == OFS_GATE);
    wr_flag = bus_wr_en & (bus_addr == OFS_FLAG);
    wr_mask = bus_wr_en & (bus_addr == OFS_MASK);
    wr_key  = bus_wr_en & (bus_addr == OFS_KEY);
  end

  isr_key_reset #(
    .DW(DATA_W), .KEY(RESET_KEY), .RST_CYCLES(RST_CYCLES)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .hit_i(wr_key), .wdata_i(bus_wdata),
    .key_ok_o(key_ok), .key_bad_o(key_bad), .core_rst_o(core_rst_o)
  );

  always_comb begin
    set_vec = {key_bad, evt_i & {NUM_EVT{~core_rst_o}}};
    clr_vec = wr_flag ? bus_wdata[NUM_SRC-1:0] : '0;
  end

  isr_src_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec),
    .wipe_i(key_ok), .flag_o(flag_q)
  );

  always_comb begin
    mask_en = wr_mask | key_ok;
    mask_d  = key_ok ? '0 : bus_wdata[NUM_SRC-1:0];
    gate_en = wr_gate | key_ok;
    gate_d  = key_ok ? 1'b0 : bus_wdata[GATE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gate_q <= 1'b0;
    else if (gate_en) gate_q <= gate_d;
  end

  isr_irq_merge #(.N(NUM_SRC)) u_merge (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_q), .flag_i(flag_q),
    .mask_i(mask_q), .irq_o(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_GATE: bus_rdata[GATE_BIT]      = gate_q;
      OFS_FLAG: bus_rdata[NUM_SRC-1:0]   = flag_q;
      OFS_MASK: bus_rdata[NUM_SRC-1:0]   = mask_q;
      default:  bus_rdata                = '0;
    endcase
  end
endmodule

// File: rtl/irq_sreg_chk.sv
module irq_sreg_chk #(
  parameter int RST_CYCLES = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [isr_pkg::ADDR_W-1:0] bus_addr,
  input logic [isr_pkg::DATA_W-1:0] bus_rdata,
  input logic [isr_pkg::NUM_EVT-1:0] evt_i,
  input logic                       irq_o,
  input logic                       core_rst_o,
  input logic [isr_pkg::NUM_SRC-1:0] flag_q,
  input logic [isr_pkg::NUM_SRC-1:0] mask_q,
  input logic                       gate_q,
  input logic                       key_ok,
  input logic                       key_bad,
  input logic                       wr_flag
);
  import isr_pkg::*;
  localparam int RW = $clog2(RST_CYCLES + 2) + 1;

  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (key_ok)     run_q <= '0;
    else if (core_rst_o) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  assert_gate_rdzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_GATE) |-> (bus_rdata[30:0] == '0));

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_rst_o && !key_ok) |=> ((flag_q[NUM_EVT-1:0] & $past(evt_i)) == $past(evt_i)));

  assert_set_beats_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && !core_rst_o && !key_ok && (evt_i != '0))
      |=> ((flag_q[NUM_EVT-1:0] & $past(evt_i)) == $past(evt_i)));

  assert_gate_holds_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gate_q) |-> !irq_o);

  assert_rst_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_o) |-> $past(key_ok));

  assert_rst_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(RST_CYCLES));

  assert_rst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> (run_q == RW'(RST_CYCLES)));

  assert_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok |=> (flag_q == '0 && mask_q == '0 && !gate_q));

  assert_badkey_R9: assert property (@(posedge clk) disable iff (!rst_n)
    key_bad |=> flag_q[BADKEY_BIT]);

  assert_evt_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst_o && !key_ok)
      |=> ((flag_q[NUM_EVT-1:0] & ~$past(flag_q[NUM_EVT-1:0])) == '0));
endmodule

bind irq_sreg_top irq_sreg_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .evt_i(evt_i), .irq_o(irq_o), .core_rst_o(core_rst_o),
  .flag_q(flag_q), .mask_q(mask_q), .gate_q(gate_q),
  .key_ok(key_ok), .key_bad(key_bad), .wr_flag(wr_flag)
);

// File: tb/tb_irq_sreg_top.sv
`timescale 1ns/1ps
module tb_irq_sreg_top;
  logic        clk;
  logic        rst_n;
  logic        bus_wr_en;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [6:0]  evt_i;
  logic        irq_o;
  logic        core_rst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  irq_sreg_top #(.RST_CYCLES(16)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_i(evt_i),
    .irq_o(irq_o), .core_rst_o(core_rst_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {address, write data, expected read-back}
  localparam logic [71:0] VEC [0:6] = '{
    {8'h28, 32'hFFFF_FFFF, 32'h0000_00FF},
    {8'h28, 32'h0000_0055, 32'h0000_0055},
    {8'h1C, 32'hFFFF_FFFF, 32'h8000_0000},
    {8'h1C, 32'h7FFF_FFFF, 32'h0000_0000},
    {8'h1C, 32'h8000_0000, 32'h8000_0000},
    {8'h24, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h20, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk);
    evt_i = e;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int hi;
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0; evt_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    rd_chk("R11 gate", 8'h1C, 32'h0);
    rd_chk("R11 flags", 8'h20, 32'h0);
    rd_chk("R11 mask", 8'h28, 32'h0);
    rd_chk("R11 key", 8'h40, 32'h0);
    chk("R11 irq", {31'b0, irq_o}, 32'h0);
    chk("R11 core_rst", {31'b0, core_rst_o}, 32'h0);

    // R1 register table walk
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd_chk("R1 readback", VEC[i][71:64], VEC[i][31:0]);
    end

    // start from gate off, mask off
    wr(8'h1C, 32'h0);
    wr(8'h28, 32'h0);

    // R2 sticky flags
    pulse(7'h05);
    rd_chk("R2 set", 8'h20, 32'h05);
    repeat (3) @(negedge clk);
    rd_chk("R2 held", 8'h20, 32'h05);
    pulse(7'h40);
    rd_chk("R2 bit6", 8'h20, 32'h45);

    // R3 write-one-to-clear
    wr(8'h20, 32'h0000_0041);
    rd_chk("R3 clear", 8'h20, 32'h04);

    // R6 gate off holds irq low
    wr(8'h28, 32'h0000_0004);
    repeat (2) @(negedge clk);
    chk("R6 gate low", {31'b0, irq_o}, 32'h0);

    // R5 registered combine: one cycle after gate write
    wr(8'h1C, 32'h8000_0000);
    chk("R5 latency", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R5 assert", {31'b0, irq_o}, 32'h1);
    wr(8'h28, 32'h0000_0000);
    @(negedge clk);
    chk("R5 masked", {31'b0, irq_o}, 32'h0);

    // R4 event and clear on same edge
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h0000_0005; evt_i = 7'h01;
    @(negedge clk);
    bus_wr_en = 1'b0; evt_i = '0;
    rd_chk("R4 event wins", 8'h20, 32'h01);

    // R9 wrong key
    wr(8'h28, 32'h0000_0080);
    wr(8'h40, 32'h0000_000B);
    rd_chk("R9 flag", 8'h20, 32'h81);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      if (core_rst_o) hi++;
      @(negedge clk);
    end
    chk("R9 no reset", hi, 0);
    chk("R9 irq", {31'b0, irq_o}, 32'h1);

    // R7 valid key pulse length, R10 events ignored mid-pulse
    pulse(7'h02);
    wr(8'h40, 32'h0000_000A);
    hi = 0;
    for (int i = 0; i < 24; i++) begin
      if (i == 5) evt_i = 7'h7F;
      if (i == 6) evt_i = 7'h00;
      if (core_rst_o) hi++;
      @(negedge clk);
    end
    chk("R7 pulse length", hi, 16);
    chk("R7 released", {31'b0, core_rst_o}, 32'h0);

    // R8 wipe, R10 nothing latched during pulse
    rd_chk("R8 R10 flags", 8'h20, 32'h0);
    rd_chk("R8 mask", 8'h28, 32'h0);
    rd_chk("R8 gate", 8'h1C, 32'h0);
    chk("R8 irq", {31'b0, irq_o}, 32'h0);

    // R2 events work again after the pulse
    pulse(7'h10);
    rd_chk("R2 after reset", 8'h20, 32'h10);

    done = 1;
    summary();
    $finish;
  end
endmodule